// File: doc/BRIEF.md
# Flagless Integer ALU with Boolean Compares

This block computes one result word for a three-address register machine that keeps no condition flags. Each operation takes a first operand and a second operand. The second operand is either a register value or a short immediate that is sign-extended to the word width. The block returns one word for write-back. Comparisons write the integer 1 or 0 into the whole result word, so a later branch only has to test the destination register for nonzero. Division and remainder by zero return 0 and raise a separate indication for that result.

The operation itself is combinational. It sits behind a single output register with a valid/ready handshake. A request is taken when `in_valid` and `in_ready` are both high. The result stays in the output register, with `out_valid` high, until the consumer takes it with `out_ready`. The input side can accept a new request in the same cycle that the held result leaves, so the block runs at one request per cycle when there is no back-pressure. While a result is held and `out_ready` is low, `in_ready` is low, and the held result and its indication do not change.

The word width and the immediate width are parameters. The defaults are 32 and 17 bits. The shift amount width is derived from the word width.

Top module: `flg_alu`

## Requirements
- R1: Operation code 0 returns A+B and code 1 returns A-B, both wrapping modulo 2^DATA_W (two's complement).
- R2: Code 2 returns the low DATA_W bits of A*B.
- R3: Code 3 returns the signed quotient truncated toward zero, and code 15 returns the signed remainder, whose sign follows the dividend. For the most negative value divided by -1, the quotient is the most negative value and the remainder is 0.
- R4: For code 3 or 15 with a zero divisor, the result is 0 and `out_div_zero` is 1 for that result. For every other code, `out_div_zero` is 0.
- R5: Codes 4, 5 and 6 return bitwise AND, OR and XOR. Code 16 returns the bitwise complement of A, and B has no effect on it.
- R6: Codes 7 to 12 compare A and B as signed values, in the order equal, not equal, less, less-or-equal, greater, greater-or-equal. The result is 1 when the comparison holds and 0 otherwise.
- R7: Code 13 shifts A left and code 14 shifts A right, filling with zeros in both cases. Only the low log2(DATA_W) bits of B set the amount.
- R8: With `in_use_imm` at 1, B is `in_imm` sign-extended from IMM_W bits, and `in_b` has no effect on the result.
- R9: Codes 17 to 31 are undefined. They return 0, with `out_div_zero` at 0.
- R10: `in_ready` equals `!out_valid || out_ready`. A result that is not accepted keeps `out_result` and `out_div_zero` unchanged.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_use_imm | input | 1 | Second operand comes from the immediate |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand, register form |
| in_imm | input | IMM_W | Immediate, sign-extended when used |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the held result |
| out_result | output | DATA_W | Result word |
| out_div_zero | output | 1 | Result came from division or remainder by zero |

## Verification
The hardest cases to reach from the ports are the two exceptional division results: a zero divisor, and the most negative dividend divided by -1. Both need a particular pair of operands to meet under code 3 or 15, and with a 32-bit word a random search almost never hits them. The bench therefore builds the block with an 8-bit word and a 5-bit immediate. It drives every dividend against a fixed set of divisors that includes 0, 1, -1 and the extremes, so each of these cases occurs many times. A stall phase holds the result while new requests wait, which shows that nothing in the held result changes.

// File: rtl/flg_alu_pkg.sv
package flg_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_SUB = 5'd1,
    OP_MUL = 5'd2,
    OP_DIV = 5'd3,
    OP_AND = 5'd4,
    OP_OR  = 5'd5,
    OP_XOR = 5'd6,
    OP_EQ  = 5'd7,
    OP_NE  = 5'd8,
    OP_LT  = 5'd9,
    OP_LE  = 5'd10,
    OP_GT  = 5'd11,
    OP_GE  = 5'd12,
    OP_SHL = 5'd13,
    OP_SHR = 5'd14,
    OP_MOD = 5'd15,
    OP_NOT = 5'd16
  } alu_op_e;

  localparam int OP_W = 5;

endpackage

// File: rtl/flg_alu_opsel.sv
module flg_alu_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 17
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/flg_alu_shift.sv
module flg_alu_shift #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  val,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  to_left,
  output logic [DATA_W-1:0]  to_right
);
  logic [DATA_W-1:0] lst [SHAMT_W+1];
  logic [DATA_W-1:0] rst [SHAMT_W+1];

  assign lst[0] = val;
  assign rst[0] = val;

  generate
    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      assign lst[s+1] = amt[s] ? (lst[s] << (2**s)) : lst[s];
      assign rst[s+1] = amt[s] ? (rst[s] >> (2**s)) : rst[s];
    end
  endgenerate

  assign to_left  = lst[SHAMT_W];
  assign to_right = rst[SHAMT_W];
endmodule

// File: rtl/flg_alu_core.sv
module flg_alu_core
  import flg_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              div_zero
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic signed [DATA_W-1:0] sa, sb;
  logic [DATA_W-1:0] shl_v, shr_v, quo, rem, prod;
  logic b_zero, ovf;
  logic lt_s, eq_v;

  assign sa = $signed(a);
  assign sb = $signed(b);

  flg_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) shift_i (
    .val      (a),
    .amt      (b[SHAMT_W-1:0]),
    .to_left  (shl_v),
    .to_right (shr_v)
  );

  assign b_zero = (b == '0);
  assign ovf    = (a == MOST_NEG) && (b == ALL_ONES);
  assign prod   = a * b;
  assign eq_v   = (a == b);
  assign lt_s   = (sa < sb);

  always_comb begin
    quo = '0;
    rem = '0;
    if (!b_zero && !ovf) begin
      quo = sa / sb;
      rem = sa % sb;
    end else if (ovf) begin
      quo = MOST_NEG;
    end
  end

  function automatic logic [DATA_W-1:0] as_word(input logic bit_v);
    return {{(DATA_W-1){1'b0}}, bit_v};
  endfunction

  always_comb begin
    result   = '0;
    div_zero = 1'b0;
    case (op)
      OP_ADD: result = a + b;
      OP_SUB: result = a - b;
      OP_MUL: result = prod;
      OP_DIV: begin result = quo; div_zero = b_zero; end
      OP_MOD: begin result = rem; div_zero = b_zero; end
      OP_AND: result = a & b;
      OP_OR:  result = a | b;
      OP_XOR: result = a ^ b;
      OP_EQ:  result = as_word(eq_v);
      OP_NE:  result = as_word(!eq_v);
      OP_LT:  result = as_word(lt_s);
      OP_LE:  result = as_word(lt_s || eq_v);
      OP_GT:  result = as_word(!lt_s && !eq_v);
      OP_GE:  result = as_word(!lt_s);
      OP_SHL: result = shl_v;
      OP_SHR: result = shr_v;
      OP_NOT: result = ~a;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/flg_alu.sv
module flg_alu
  import flg_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic              in_use_imm,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_div_zero
);
  logic [DATA_W-1:0] opnd_b, comb_res;
  logic comb_dz, take;

  flg_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opsel_i (
    .use_imm (in_use_imm),
    .reg_b   (in_b),
    .imm     (in_imm),
    .opnd_b  (opnd_b)
  );

  flg_alu_core #(.DATA_W(DATA_W)) core_i (
    .op       (in_op),
    .a        (in_a),
    .b        (opnd_b),
    .result   (comb_res),
    .div_zero (comb_dz)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_div_zero <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_result   <= comb_res;
      out_div_zero <= comb_dz;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/flg_alu_chk.sv
module flg_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_op,
  input logic              in_use_imm,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_div_zero
);
  localparam int SHAMT_W = $clog2(DATA_W);
  logic acc;
  logic [DATA_W-1:0] imm_sx;
  assign acc = in_valid && in_ready;
  assign imm_sx = DATA_W'($signed(in_imm));

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_div_zero)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R10
  AST_ADD_REG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'd0 && !in_use_imm |=> out_result == $past(in_a) + $past(in_b)); // R1
  AST_ADD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'd0 && in_use_imm |=> out_result == $past(in_a) + $past(imm_sx)); // R8
  AST_DZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_div_zero |-> out_result == '0); // R4
  AST_DZ_ONLY_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op != 5'd3 && in_op != 5'd15 |=> !out_div_zero); // R4
  AST_NOT_B_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'd16 |=> out_result == ~$past(in_a)); // R5
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= 5'd7 && in_op <= 5'd12 |=> out_result <= DATA_W'(1)); // R6
  AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'd14 && !in_use_imm && in_b[SHAMT_W-1:0] != '0 |=> !out_result[DATA_W-1]); // R7
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= 5'd17 |=> out_result == '0 && !out_div_zero); // R9
endmodule

bind flg_alu flg_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_use_imm(in_use_imm), .in_a(in_a), .in_b(in_b),
  .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_div_zero(out_div_zero)
);

// File: tb/flg_alu_tb_top.sv
module flg_alu_tb_top;
  localparam int DW = 8;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_use_imm = 1'b0;
  logic [4:0] in_op = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic [IW-1:0] in_imm = '0;
  logic out_valid, out_ready = 1'b1, out_div_zero;
  logic [DW-1:0] out_result;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flg_alu #(.DATA_W(DW), .IMM_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_use_imm(in_use_imm), .in_a(in_a), .in_b(in_b),
    .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_div_zero(out_div_zero)
  );

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R1";
      2: return "R2";
      3, 15: return "R3";
      4, 5, 6, 16: return "R5";
      7, 8, 9, 10, 11, 12: return "R6";
      13, 14: return "R7";
      default: return "R9";
    endcase
  endfunction

  // expected {div_zero, result} from the requirement arithmetic
  function automatic logic [DW:0] model(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    int sa, sb, r, ua, ub;
    logic dz;
    sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    dz = 1'b0; r = 0;
    case (op)
      0: r = sa + sb;
      1: r = sa - sb;
      2: r = sa * sb;
      3: if (sb == 0) dz = 1'b1; else if (sa == -128 && sb == -1) r = -128; else r = sa / sb;
      15: if (sb == 0) dz = 1'b1; else if (sa == -128 && sb == -1) r = 0; else r = sa % sb;
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      7: r = (sa == sb) ? 1 : 0;
      8: r = (sa != sb) ? 1 : 0;
      9: r = (sa < sb) ? 1 : 0;
      10: r = (sa <= sb) ? 1 : 0;
      11: r = (sa > sb) ? 1 : 0;
      12: r = (sa >= sb) ? 1 : 0;
      13: r = ua << (ub % 8);
      14: r = ua >> (ub % 8);
      16: r = ~ua;
      default: r = 0;
    endcase
    return {dz, r[DW-1:0]};
  endfunction

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input int op, input logic imm_mode, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic [IW-1:0] imm);
    logic [DW-1:0] bb;
    @(negedge clk);
    in_valid = 1'b1; in_op = op[4:0]; in_use_imm = imm_mode;
    in_a = a; in_b = b; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
    bb = imm_mode ? DW'($signed(imm)) : b;
    check(imm_mode ? "R8" : req_of(op), {out_div_zero, out_result}, model(op, a, bb));
    check("R10", {8'd0, out_valid}, {8'd0, 1'b1});
  endtask

  localparam logic [DW-1:0] BV [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08,
                                        8'h7f, 8'h80, 8'h81, 8'hfe, 8'hff, 8'h55};

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {7'd0, out_valid, in_ready}, {7'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", {7'd0, out_valid, in_ready}, {7'd0, 1'b0, 1'b1});

    // register form: every dividend/first operand against the divisor set (R1..R7, R9)
    for (int op = 0; op <= 16; op++)
      for (int ai = 0; ai < 256; ai++)
        for (int bi = 0; bi < 12; bi++)
          run_one(op, 1'b0, ai[DW-1:0], BV[bi], '0);

    // undefined codes R9
    for (int op = 17; op < 32; op++)
      for (int bi = 0; bi < 12; bi++)
        run_one(op, 1'b0, BV[bi] ^ 8'h3c, BV[bi], '0);

    // immediate form, in_b carries junk that must not matter (R8)
    for (int op = 0; op <= 16; op++)
      for (int ii = 0; ii < 32; ii++)
        for (int ai = 0; ai < 12; ai++)
          run_one(op, 1'b1, BV[ai], ~BV[ai] ^ ii[DW-1:0], ii[IW-1:0]);

    // back-pressure R10
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 5'd0; in_use_imm = 1'b0; in_a = 8'd20; in_b = 8'd22;
    @(negedge clk);
    check("R10", {out_div_zero, out_result}, {1'b0, 8'd42});
    in_op = 5'd3; in_a = 8'd9; in_b = 8'd0;
    for (int k = 0; k < 3; k++) begin
      check("R10", {7'd0, in_ready, out_valid}, {7'd0, 1'b0, 1'b1});
      @(negedge clk);
      check("R10", {out_div_zero, out_result}, {1'b0, 8'd42});
    end
    out_ready = 1'b1;
    #0.1;
    check("R10", {7'd0, in_ready, out_valid}, {7'd0, 1'b1, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    check("R4", {out_div_zero, out_result}, {1'b1, 8'd0});
    @(negedge clk);
    check("R10", {8'd0, out_valid}, {8'd0, 1'b0});

    done = 1;
    finish_run();
  end
endmodule